// File: doc/BRIEF.md
# Hot-Swap Channel Fault Sequencer

This block is the digital control sequencer for one switched power rail of a hot-swap controller. It turns a small set of synchronous flags into gate and soft-start control for an external pass transistor. The flags are: a power-on-valid input, an active-low channel enable, a restart-policy select, and digitized comparator results for regulated overcurrent, severe overcurrent and output-in-range. The analog loop, comparators and charge pump sit outside the block. A clocked counter replaces the timing capacitor, and one full count of `TMO_CYCLES` clocks stands for one capacitor charge.

When the channel is enabled, soft-start begins and the fault window opens in the same cycle. The output has to come into range before the window closes, or the channel shuts down. While the channel runs, overcurrent reopens the same window. A severe overcurrent first gives a single-cycle hard gate pulldown, and if it persists the channel falls into timed regulation. When the window expires, the channel either latches off until enable is cycled, or it waits `RETRY_CYCLES` complete windows and restarts, and it keeps repeating this while the fault remains.

Top module: `hsw_chan_seq`

## Requirements
- R1: While `por_ok` is low, one clock later and for as long as it stays low: `gate_en`=0, `gate_fast_pd`=0, `ss_clr`=1, `fault_n`=1 and `pgood_n`=1. Enable has no effect in this condition.
- R2: With `por_ok` high, a low `en_n` sampled while the channel is off gives `gate_en`=1 and `ss_clr`=0 in the next cycle. The fault window starts in that same cycle.
- R3: If `vout_good` stays low through soft-start, `gate_en` is high for exactly `TMO_CYCLES` cycles and the channel shuts down in the following cycle. If `vout_good` arrives earlier, the channel enters the running state with `fault_n` still 1.
- R4: In the running state, `oc_flag` opens a `TMO_CYCLES`-cycle window with the gate still driven (`gate_en`=1). If the flag drops before the window expires, the channel returns to running and the window restarts from zero the next time the flag is raised.
- R5: `woc_flag` in the running state gives exactly one cycle of `gate_fast_pd`=1 with `gate_en`=0. After that cycle, the channel returns to running if the flag has cleared, or enters timed regulation (`gate_en`=1) if it is still high.
- R6: When a window expires, the outputs become `gate_en`=0, `gate_fast_pd`=1, `ss_clr`=1 and `fault_n`=0.
- R7: If `retry_n` is high when the window expires, the fault state holds regardless of any flag. Only `en_n` going high and then low again releases it.
- R8: If `retry_n` is low when the window expires, the channel stays faulted for exactly 64 × `TMO_CYCLES` cycles and then restarts soft-start (`fault_n`=1, `gate_en`=1). A failed restart faults again and repeats this indefinitely. A successful restart reaches running with `fault_n`=1.
- R9: `pgood_n` equals the inverse of (`por_ok` AND `vout_good`) delayed by one clock.
- R10: `en_n` high in any state gives the off outputs one clock later (`gate_en`=0, `ss_clr`=1, `fault_n`=1). It also clears the retry count, so a later restart wait lasts the full 64 windows.
- R11: If `vout_good` rises in the very cycle the soft-start window reaches terminal count, the output-good event wins. The channel runs and `fault_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| por_ok | input | 1 | Supply above power-on threshold |
| en_n | input | 1 | Channel enable, active low |
| retry_n | input | 1 | Low: automatic restart; high: latch off |
| oc_flag | input | 1 | Current at regulation level |
| woc_flag | input | 1 | Severe overcurrent |
| vout_good | input | 1 | Output voltage in range |
| gate_en | output | 1 | Drive external gate on |
| gate_fast_pd | output | 1 | Hard gate pulldown |
| ss_clr | output | 1 | Hold soft-start capacitor discharged |
| fault_n | output | 1 | Fault indication, active low |
| pgood_n | output | 1 | Power good, active low |

## Verification
The soft-start deadline and the output-good event can land in the same clock: the timer reaching its terminal value and `vout_good` rising together. The bench provokes this by enabling the channel and counting exactly `TMO_CYCLES` clocks before raising `vout_good`. The judgement is that the channel runs with no fault, because output-good has priority. The same counting, one window later, is used on the overcurrent path: the flag is dropped in the terminal cycle of the window, and the bench shows that a fresh overcurrent then gets a full window again.

// File: rtl/hsw_seq_pkg.sv
package hsw_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_SOFT  = 3'd1,
      ST_RUN   = 3'd2,
      ST_KICK  = 3'd3,
      ST_REG   = 3'd4,
      ST_LATCH = 3'd5,
      ST_WAIT  = 3'd6
   } hsw_state_e;

   // states in which the fault window counter advances
   function automatic logic window_active(hsw_state_e s);
      return (s == ST_SOFT) || (s == ST_REG) || (s == ST_WAIT);
   endfunction

endpackage

// File: rtl/hsw_tmo_timer.sv
module hsw_tmo_timer #(
   parameter int TMO_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tmo
);
   localparam int CW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

   logic [CW-1:0] cnt;

   assign tmo = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tmo)    cnt <= '0;
      else             cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/hsw_retry_ctr.sv
module hsw_retry_ctr #(
   parameter int RETRY_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic win_end,
   output logic done
);
   localparam int RW = (RETRY_CYCLES > 2) ? $clog2(RETRY_CYCLES) : 1;
   localparam logic [RW-1:0] LAST = RW'(RETRY_CYCLES - 1);

   logic [RW-1:0] cnt;

   assign done = active && win_end && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!active)  cnt <= '0;
      else if (done)     cnt <= '0;
      else if (win_end)  cnt <= cnt + RW'(1);
   end
endmodule

// File: rtl/hsw_chan_seq.sv
module hsw_chan_seq #(
   parameter int TMO_CYCLES   = 1024,
   parameter int RETRY_CYCLES = 64,
   parameter bit PG_REGISTER  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic por_ok,
   input  logic en_n,
   input  logic retry_n,
   input  logic oc_flag,
   input  logic woc_flag,
   input  logic vout_good,
   output logic gate_en,
   output logic gate_fast_pd,
   output logic ss_clr,
   output logic fault_n,
   output logic pgood_n
);
   import hsw_seq_pkg::*;

   generate
      if (TMO_CYCLES < 2) begin : g_bad_tmo
         $error("hsw_chan_seq: TMO_CYCLES must be at least 2");
      end
      if (RETRY_CYCLES < 2) begin : g_bad_retry
         $error("hsw_chan_seq: RETRY_CYCLES must be at least 2");
      end
   endgenerate

   hsw_state_e st, st_nxt;
   logic       tmo, retry_done;
   hsw_state_e fault_dest;

   hsw_tmo_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (window_active(st)),
      .tmo   (tmo)
   );

   hsw_retry_ctr #(.RETRY_CYCLES(RETRY_CYCLES)) u_retry (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (st == ST_WAIT),
      .win_end (tmo),
      .done    (retry_done)
   );

   assign fault_dest = retry_n ? ST_LATCH : ST_WAIT;

   always_comb begin
      st_nxt = st;
      if (!por_ok || en_n) begin
         st_nxt = ST_OFF;
      end else begin
         case (st)
            ST_OFF:   st_nxt = ST_SOFT;
            ST_SOFT:  if (vout_good)               st_nxt = ST_RUN;
                      else if (tmo)                st_nxt = fault_dest;
            ST_RUN:   if (woc_flag)                st_nxt = ST_KICK;
                      else if (oc_flag)            st_nxt = ST_REG;
            ST_KICK:  if (woc_flag || oc_flag)     st_nxt = ST_REG;
                      else                         st_nxt = ST_RUN;
            ST_REG:   if (!oc_flag && !woc_flag)   st_nxt = ST_RUN;
                      else if (tmo)                st_nxt = fault_dest;
            ST_LATCH: st_nxt = ST_LATCH;
            ST_WAIT:  if (retry_done)              st_nxt = ST_SOFT;
            default:  st_nxt = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_OFF;
      else        st <= st_nxt;
   end

   assign gate_en      = (st == ST_SOFT) || (st == ST_RUN) || (st == ST_REG);
   assign gate_fast_pd = (st == ST_KICK) || (st == ST_LATCH) || (st == ST_WAIT);
   assign ss_clr       = (st == ST_OFF) || (st == ST_LATCH) || (st == ST_WAIT);
   assign fault_n      = !((st == ST_LATCH) || (st == ST_WAIT));

   generate
      if (PG_REGISTER) begin : g_pg_ff
         logic pg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pg_q <= 1'b0;
            else        pg_q <= por_ok && vout_good;
         end
         assign pgood_n = !pg_q;
      end else begin : g_pg_comb
         assign pgood_n = !(por_ok && vout_good);
      end
   endgenerate
endmodule

// File: rtl/hsw_chan_seq_chk.sv
module hsw_chan_seq_chk #(
   parameter bit PG_REGISTER = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic por_ok,
   input logic en_n,
   input logic woc_flag,
   input logic vout_good,
   input logic gate_en,
   input logic gate_fast_pd,
   input logic ss_clr,
   input logic fault_n,
   input logic pgood_n
);
   AST_POR_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !por_ok |=> (!gate_en && !gate_fast_pd && ss_clr && fault_n)); // R1

   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en) |-> (!$past(en_n) && $past(por_ok))); // R2

   AST_KICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_fast_pd && fault_n) |=> !(gate_fast_pd && fault_n)); // R5

   AST_KICK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_fast_pd) && fault_n) |-> $past(woc_flag)); // R5

   AST_FAULT_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |-> (!gate_en && gate_fast_pd && ss_clr)); // R6

   AST_FAULT_FROM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_n) |-> $past(gate_en)); // R6

   AST_EN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      en_n |=> (!gate_en && fault_n && ss_clr)); // R10

   generate
      if (PG_REGISTER) begin : g_pg_chk
         AST_PG_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (por_ok && vout_good) |=> !pgood_n); // R9
         AST_PG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !(por_ok && vout_good) |=> pgood_n); // R9
      end
   endgenerate
endmodule

bind hsw_chan_seq hsw_chan_seq_chk #(.PG_REGISTER(PG_REGISTER)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .por_ok       (por_ok),
   .en_n         (en_n),
   .woc_flag     (woc_flag),
   .vout_good    (vout_good),
   .gate_en      (gate_en),
   .gate_fast_pd (gate_fast_pd),
   .ss_clr       (ss_clr),
   .fault_n      (fault_n),
   .pgood_n      (pgood_n)
);

// File: tb/hsw_chan_seq_test.sv
`timescale 1ns/1ps
module hsw_chan_seq_test;
   localparam int TMO = 16;
   localparam int NRETRY = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por_ok = 1'b0, en_n = 1'b1, retry_n = 1'b1;
   logic oc_flag = 1'b0, woc_flag = 1'b0, vout_good = 1'b0;
   logic gate_en, gate_fast_pd, ss_clr, fault_n, pgood_n;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   hsw_chan_seq #(.TMO_CYCLES(TMO), .RETRY_CYCLES(NRETRY), .PG_REGISTER(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_n(en_n), .retry_n(retry_n),
      .oc_flag(oc_flag), .woc_flag(woc_flag), .vout_good(vout_good),
      .gate_en(gate_en), .gate_fast_pd(gate_fast_pd), .ss_clr(ss_clr),
      .fault_n(fault_n), .pgood_n(pgood_n)
   );

   task automatic tick(input int n = 1);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic go_off();
      en_n = 1'b1; oc_flag = 1'b0; woc_flag = 1'b0; vout_good = 1'b0;
      tick(2);
   endtask

   task automatic bring_up();
      en_n = 1'b0; tick();
      vout_good = 1'b1; tick();
   endtask

   task automatic t_reset();
      tick(2);
      rst_n = 1'b1;
      tick();
      chk("R1", "gate_en after reset", gate_en, 1'b0);
      chk("R1", "fast_pd after reset", gate_fast_pd, 1'b0);
      chk("R1", "ss_clr after reset", ss_clr, 1'b1);
      chk("R1", "fault_n after reset", fault_n, 1'b1);
      chk("R1", "pgood_n after reset", pgood_n, 1'b1);
   endtask

   task automatic t_por();
      en_n = 1'b0; tick(3);
      chk("R1", "gate held without por", gate_en, 1'b0);
      por_ok = 1'b1; tick();
      chk("R2", "gate on after enable", gate_en, 1'b1);
      chk("R2", "ss released", ss_clr, 1'b0);
      vout_good = 1'b1; tick();
      chk("R9", "pgood asserted", pgood_n, 1'b0);
      por_ok = 1'b0; tick();
      chk("R1", "gate off on por drop", gate_en, 1'b0);
      chk("R1", "ss_clr on por drop", ss_clr, 1'b1);
      chk("R1", "pgood off on por drop", pgood_n, 1'b1);
      por_ok = 1'b1;
      go_off();
   endtask

   task automatic t_soft_timeout_latch();
      retry_n = 1'b1; go_off();
      en_n = 1'b0; tick();
      chk("R2", "soft-start gate", gate_en, 1'b1);
      tick(TMO - 1);
      chk("R3", "gate still on last window cycle", gate_en, 1'b1);
      chk("R3", "no fault before expiry", fault_n, 1'b1);
      tick();
      chk("R6", "fault asserted", fault_n, 1'b0);
      chk("R6", "gate off", gate_en, 1'b0);
      chk("R6", "fast pulldown", gate_fast_pd, 1'b1);
      chk("R6", "ss cleared", ss_clr, 1'b1);
      tick(50 * TMO);
      chk("R7", "latched after long wait", fault_n, 1'b0);
      vout_good = 1'b1; tick(2);
      chk("R7", "latched ignores vout_good", gate_en, 1'b0);
      vout_good = 1'b0;
      en_n = 1'b1; tick();
      chk("R7", "fault released by enable off", fault_n, 1'b1);
      en_n = 1'b0; tick();
      chk("R7", "restart after enable cycle", gate_en, 1'b1);
   endtask

   task automatic t_coincide();
      go_off();
      en_n = 1'b0; tick();
      tick(TMO - 1);
      vout_good = 1'b1; tick();
      chk("R11", "good wins at terminal count fault_n", fault_n, 1'b1);
      chk("R11", "good wins at terminal count gate", gate_en, 1'b1);
      tick(3 * TMO);
      chk("R3", "running stays without fault", fault_n, 1'b1);
   endtask

   task automatic t_oc();
      retry_n = 1'b1; go_off(); bring_up();
      oc_flag = 1'b1; tick();
      chk("R4", "gate driven in regulation", gate_en, 1'b1);
      tick(TMO - 1);
      chk("R4", "no fault at last window cycle", fault_n, 1'b1);
      oc_flag = 1'b0; tick();
      chk("R4", "back to running", gate_en, 1'b1);
      chk("R4", "no fault after clear", fault_n, 1'b1);
      oc_flag = 1'b1; tick(); tick(TMO - 1);
      chk("R4", "window restarted from zero", fault_n, 1'b1);
      tick();
      chk("R6", "oc timeout faults", fault_n, 1'b0);
      oc_flag = 1'b0;
   endtask

   task automatic t_woc();
      go_off(); bring_up();
      woc_flag = 1'b1; tick();
      chk("R5", "kick pulldown", gate_fast_pd, 1'b1);
      chk("R5", "kick gate off", gate_en, 1'b0);
      chk("R5", "kick no fault", fault_n, 1'b1);
      woc_flag = 1'b0; tick();
      chk("R5", "kick released", gate_fast_pd, 1'b0);
      chk("R5", "gate back after kick", gate_en, 1'b1);
      woc_flag = 1'b1; tick(); tick();
      chk("R5", "persist enters regulation gate", gate_en, 1'b1);
      chk("R5", "persist pulldown released", gate_fast_pd, 1'b0);
      tick(TMO - 1);
      chk("R5", "regulation no fault yet", fault_n, 1'b1);
      tick();
      chk("R5", "persisting woc times out", fault_n, 1'b0);
      woc_flag = 1'b0;
   endtask

   task automatic t_retry();
      retry_n = 1'b0; go_off();
      en_n = 1'b0; tick(); tick(TMO);
      chk("R8", "faulted into wait", fault_n, 1'b0);
      tick(NRETRY * TMO - 1);
      chk("R8", "still waiting at last wait cycle", fault_n, 1'b0);
      chk("R8", "gate off while waiting", gate_en, 1'b0);
      tick();
      chk("R8", "restart fault cleared", fault_n, 1'b1);
      chk("R8", "restart gate", gate_en, 1'b1);
      chk("R8", "restart ss released", ss_clr, 1'b0);
      tick(TMO);
      chk("R8", "failed retry faults again", fault_n, 1'b0);
      tick(NRETRY * TMO);
      chk("R8", "second restart", gate_en, 1'b1);
      vout_good = 1'b1; tick();
      chk("R8", "successful retry runs", gate_en, 1'b1);
      tick(2 * TMO);
      chk("R8", "successful retry no fault", fault_n, 1'b1);
   endtask

   task automatic t_en_clear();
      retry_n = 1'b0; go_off();
      en_n = 1'b0; tick(); tick(TMO);
      tick(10 * TMO + 3);
      en_n = 1'b1; tick();
      chk("R10", "fault cleared by disable", fault_n, 1'b1);
      chk("R10", "gate off by disable", gate_en, 1'b0);
      chk("R10", "ss_clr by disable", ss_clr, 1'b1);
      en_n = 1'b0; tick(); tick(TMO);
      tick(NRETRY * TMO - 1);
      chk("R10", "retry count restarted full wait", fault_n, 1'b0);
      tick();
      chk("R10", "restart after full wait", gate_en, 1'b1);
      vout_good = 1'b1; tick();
      en_n = 1'b1; tick();
      chk("R10", "disable from running", gate_en, 1'b0);
   endtask

   task automatic t_pgood();
      go_off();
      vout_good = 1'b1;
      #2;
      chk("R9", "pgood delayed one clock", pgood_n, 1'b1);
      tick();
      chk("R9", "pgood follows flag", pgood_n, 1'b0);
      vout_good = 1'b0; tick();
      chk("R9", "pgood drops with flag", pgood_n, 1'b1);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      #3;
      t_reset();
      t_por();
      t_soft_timeout_latch();
      t_coincide();
      t_oc();
      t_woc();
      t_retry();
      t_en_clear();
      t_pgood();
      finished = 1'b1;
      finish_run();
   end
endmodule